// File: doc/BRIEF.md
# I2C Slave Address and Extension-Code Detector

This block sits on an I2C bus as a slave and looks at the first byte after every START condition. SCL and SDA first pass through multi-flop synchronizers into the system clock domain. START and STOP conditions and SCL edges are then found from the synchronized levels. Eight bits are shifted in on SCL rising edges. On the falling edge of the eighth clock, the byte is sorted into two classes. It is an address match when its seven address bits equal the programmed local address. It is a reserved extension code when its top nibble is all zeros or all ones. One interrupt pulse goes out when either class applies.

Both classes make the slave take part in the transfer, and the R/W bit of the address byte is latched as the transfer direction. A release strobe takes the slave out of the current transfer. It then ignores the bus until the next START. The flags stay valid until a clear strobe or the next START.

In data bytes, the block can also check transmission. When the local side drives a byte onto SDA, the level sampled back from the bus is compared with that byte at the end of the byte. A difference sets a transmit-error flag.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, `irq`, `addr_match`, `ext_code`, `rw_dir`, `slave_active` and `tx_err` are all 0.
- R2: When bits [7:1] of the address byte equal `own_addr`, `addr_match` is set to 1 and `slave_active` is set to 1. The address byte is sent MSB first after a START.
- R3: `irq` is a single one-cycle pulse per qualifying address byte. It appears only after the falling edge of the eighth SCL clock, and not after the eighth rising edge.
- R4: When bits [7:4] of the address byte are 4'b0000 or 4'b1111, `ext_code` is set to 1, `irq` pulses and `slave_active` is set to 1, whether or not the address matches.
- R5: The all-zero address byte (general call) sets `ext_code` and leaves `addr_match` at 0 when `own_addr` is non-zero.
- R6: With `own_addr` = 7'b11110xx (10-bit prefix), a received byte 11110yyR sets `ext_code`. `addr_match` is also set only when yy equals xx.
- R7: An address byte that neither matches nor is an extension code sets no flag, gives no `irq` and leaves `slave_active` at 0.
- R8: `rw_dir` takes bit 0 of the address byte whenever a match or an extension code is detected.
- R9: A `release_req` pulse clears `slave_active`. Until the next START, further bytes cause no `irq` and no `tx_err`. A new START re-arms detection.
- R10: In a data byte of an active transfer with `tx_en` = 1, `tx_err` is set when the 8 bits sampled from SDA differ from `tx_byte`, and stays 0 when they are equal.
- R11: A START clears `addr_match`, `ext_code` and `tx_err`. A `flag_clr` pulse also clears those three flags.
- R12: After a STOP and before the next START, SCL activity causes no `irq` and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level (asynchronous) |
| sda_in | input | 1 | Bus data level (asynchronous) |
| own_addr | input | 7 | Programmed local slave address |
| tx_en | input | 1 | Local side is driving data bytes |
| tx_byte | input | 8 | Byte the local side loaded for transmission |
| release_req | input | 1 | Pulse: leave the current transfer |
| flag_clr | input | 1 | Pulse: clear match, extension and transmit-error flags |
| irq | output | 1 | One-cycle address-phase interrupt |
| addr_match | output | 1 | Address matched local address |
| ext_code | output | 1 | Reserved extension code received |
| rw_dir | output | 1 | Latched R/W bit of the accepted address byte |
| slave_active | output | 1 | Slave is taking part in the current transfer |
| tx_err | output | 1 | Transmitted byte differed from bus readback |

## Verification
The case that is hardest to reach is a 10-bit prefix byte that matches the top nibble but not the two high address bits. Random bytes seldom land on it, so directed bytes are built from `own_addr` with the yy field flipped. The interrupt's placement between the eighth rising and falling SCL edge is also found only by stopping the stimulus mid-bit. A bench task splits the eighth clock and counts pulses on each side of the falling edge. Random address bytes, with the local address forced equal about a third of the time, cover the other combinations.

// File: rtl/i2c_adet_pkg.sv
package i2c_adet_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic match;
        logic ext;
        logic rw;
    } addr_class_t;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_ADDR     = 2'd1,
        PH_DATA     = 2'd2,
        PH_RELEASED = 2'd3
    } phase_e;

    function automatic addr_class_t classify(input logic [BYTE_W-1:0] b,
                                             input logic [ADDR_W-1:0] own);
        addr_class_t c;
        c.match = (b[BYTE_W-1:1] == own);
        c.ext   = (b[BYTE_W-1:BYTE_W-4] == 4'b0000) ||
                  (b[BYTE_W-1:BYTE_W-4] == 4'b1111);
        c.rw    = b[0];
        return c;
    endfunction

endpackage

// File: rtl/i2c_adet_sync.sv
module i2c_adet_sync
    import i2c_adet_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain    <= '1;
                prev[ln] <= 1'b1;
            end else begin
                chain    <= {chain[STAGES-2:0], raw[ln]};
                prev[ln] <= chain[STAGES-1];
            end
        end
        assign lvl[ln] = chain[STAGES-1];
    end

    always_comb begin
        ev.start = lvl[1] && prev[1] && !lvl[0] &&  prev[0];
        ev.stop  = lvl[1] && prev[1] &&  lvl[0] && !prev[0];
        ev.rise  = lvl[1] && !prev[1];
        ev.fall  = !lvl[1] && prev[1];
        ev.sda   = lvl[0];
    end

endmodule

// File: rtl/i2c_adet_shifter.sv
module i2c_adet_shifter
    import i2c_adet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              en,
    output logic [BYTE_W-1:0] shreg,
    output logic              byte_done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (ev.start) begin
            cnt <= '0;
        end else if (en) begin
            if (ev.rise && cnt <= CNT_W'(BYTE_W)) begin
                shreg <= {shreg[BYTE_W-2:0], ev.sda};
                cnt   <= cnt + 1'b1;
            end else if (ev.fall && cnt == CNT_W'(BYTE_W + 1)) begin
                cnt <= '0;
            end
        end
    end

    assign byte_done = en && ev.fall && (cnt == CNT_W'(BYTE_W));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BYTE_W + 1)); // R3

endmodule

// File: rtl/i2c_adet_flags.sv
module i2c_adet_flags
    import i2c_adet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              addr_done,
    input  logic              data_done,
    input  addr_class_t       cls,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              flag_clr,
    input  logic              release_req,
    output logic              irq,
    output logic              match_q,
    output logic              ext_q,
    output logic              rw_q,
    output logic              active_q,
    output logic              txerr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            match_q  <= 1'b0;
            ext_q    <= 1'b0;
            rw_q     <= 1'b0;
            active_q <= 1'b0;
            txerr_q  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                match_q  <= 1'b0;
                ext_q    <= 1'b0;
                txerr_q  <= 1'b0;
                active_q <= 1'b0;
            end else begin
                if (flag_clr) begin
                    match_q <= 1'b0;
                    ext_q   <= 1'b0;
                    txerr_q <= 1'b0;
                end
                if (release_req)
                    active_q <= 1'b0;
                if (addr_done) begin
                    match_q <= cls.match;
                    ext_q   <= cls.ext;
                    if (cls.match || cls.ext) begin
                        rw_q     <= cls.rw;
                        active_q <= 1'b1;
                        irq      <= 1'b1;
                    end
                end
                if (data_done && active_q && tx_en && (rx_byte != tx_byte))
                    txerr_q <= 1'b1;
            end
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R3
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (match_q || ext_q)); // R2
    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq |-> active_q); // R4

endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect
    import i2c_adet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              release_req,
    input  logic              flag_clr,
    output logic              irq,
    output logic              addr_match,
    output logic              ext_code,
    output logic              rw_dir,
    output logic              slave_active,
    output logic              tx_err
);
    bus_ev_t           ev;
    phase_e            phase;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;
    logic              shift_en;
    logic              addr_done;
    logic              data_done;
    addr_class_t       cls;

    i2c_adet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    assign shift_en = (phase == PH_ADDR) || (phase == PH_DATA);

    i2c_adet_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .en        (shift_en),
        .shreg     (shreg),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_IDLE;
        else if (ev.start)
            phase <= PH_ADDR;
        else if (ev.stop)
            phase <= PH_IDLE;
        else if (release_req && phase != PH_IDLE)
            phase <= PH_RELEASED;
        else if (byte_done && phase == PH_ADDR)
            phase <= PH_DATA;
    end

    assign cls       = classify(shreg, own_addr);
    assign addr_done = byte_done && (phase == PH_ADDR) && !release_req && !ev.start;
    assign data_done = byte_done && (phase == PH_DATA) && !release_req && !ev.start;

    i2c_adet_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .start       (ev.start),
        .addr_done   (addr_done),
        .data_done   (data_done),
        .cls         (cls),
        .rx_byte     (shreg),
        .tx_en       (tx_en),
        .tx_byte     (tx_byte),
        .flag_clr    (flag_clr),
        .release_req (release_req),
        .irq         (irq),
        .match_q     (addr_match),
        .ext_q       (ext_code),
        .rw_q        (rw_dir),
        .active_q    (slave_active),
        .txerr_q     (tx_err)
    );

    AST_EXT_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_code) |-> (shreg[7:4] == 4'b0000 || shreg[7:4] == 4'b1111)); // R4
    AST_MATCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_match) |-> (shreg[7:1] == $past(own_addr))); // R2
    AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RELEASED) |-> (!irq && !slave_active)); // R9
    AST_TXERR_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_err) |-> ($past(phase) == PH_DATA)); // R10
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IDLE) |-> !irq); // R12

endmodule

// File: tb/sim_i2c_addr_detect.sv
`timescale 1ns/100ps
module sim_i2c_addr_detect;
    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       tx_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       release_req = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq, addr_match, ext_code, rw_dir, slave_active, tx_err;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_addr_detect u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .own_addr(own_addr), .tx_en(tx_en), .tx_byte(tx_byte),
        .release_req(release_req), .flag_clr(flag_clr),
        .irq(irq), .addr_match(addr_match), .ext_code(ext_code),
        .rw_dir(rw_dir), .slave_active(slave_active), .tx_err(tx_err)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (HP) @(posedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
        hold();
    endtask

    task automatic bus_start();
        @(negedge clk); sda = 1'b1; hold();
        scl = 1'b1; hold();
        sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        @(negedge clk); sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); sda = b; hold();
        scl = 1'b1; hold();
        scl = 1'b0; hold();
    endtask

    // address byte with split eighth clock; returns irq counts before/after the falling edge
    task automatic send_addr(input logic [7:0] b, output int before_fall, output int after_fall);
        int base;
        base = irq_cnt;
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        @(negedge clk); sda = b[0]; hold();
        scl = 1'b1; hold(); hold();
        before_fall = irq_cnt - base;
        scl = 1'b0; hold(); hold();
        after_fall = irq_cnt - base;
        send_bit(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(1'b1);
    endtask

    function automatic logic f_ext(input logic [7:0] b);
        return (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
    endfunction

    function automatic logic f_match(input logic [7:0] b, input logic [6:0] own);
        return b[7:1] == own;
    endfunction

    task automatic addr_case(input string req, input logic [7:0] b);
        int bf, af;
        logic m, e;
        m = f_match(b, own_addr);
        e = f_ext(b);
        bus_start();
        send_addr(b, bf, af);
        check({req, " irq before 8th fall"}, bf, 0);
        check({req, " irq count"}, af, (m || e) ? 1 : 0);
        check({req, " addr_match"}, addr_match, m);
        check({req, " ext_code"}, ext_code, e);
        check({req, " slave_active"}, slave_active, m || e);
        if (m || e) check({req, " rw_dir R8"}, rw_dir, b[0]);
    endtask

    initial begin
        int bf, af, base;
        logic [7:0] b;
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        hold();
        // R1
        check("R1 irq", irq, 0);
        check("R1 flags", {addr_match, ext_code, rw_dir, slave_active, tx_err}, 0);

        // R2 / R3 / R8
        own_addr = 7'h2A;
        addr_case("R2", {7'h2A, 1'b1});
        bus_stop();
        // R7
        addr_case("R7", {7'h35, 1'b0});
        check("R7 no flags", {addr_match, ext_code, slave_active}, 0);
        bus_stop();
        // R4 upper nibble 1111 and 0000
        addr_case("R4", 8'hF9);
        bus_stop();
        addr_case("R4", 8'h0B);
        bus_stop();
        // R5 general call
        addr_case("R5", 8'h00);
        check("R5 match", addr_match, 0);
        check("R5 ext", ext_code, 1);
        bus_stop();

        // R6 10-bit prefix
        own_addr = 7'b1111010;
        addr_case("R6 yy equal", {7'b1111010, 1'b0});
        check("R6 both", {addr_match, ext_code}, 2'b11);
        bus_stop();
        addr_case("R6 yy differ", {7'b1111100, 1'b1});
        check("R6 ext only", {addr_match, ext_code}, 2'b01);
        bus_stop();

        // R10 transmit compare
        own_addr = 7'h51;
        addr_case("R10 setup", {7'h51, 1'b1});
        tx_en = 1'b1; tx_byte = 8'hA5;
        send_byte(8'hA5);
        check("R10 equal byte", tx_err, 0);
        send_byte(8'h5A);
        check("R10 mismatch byte", tx_err, 1);
        // R11 flag_clr
        pulse(flag_clr);
        check("R11 flag_clr", {addr_match, ext_code, tx_err}, 0);
        send_byte(8'h00);
        check("R10 mismatch again", tx_err, 1);
        bus_stop();
        // R11 start clears
        bus_start();
        check("R11 start clears", {addr_match, ext_code, tx_err}, 0);
        send_addr({7'h51, 1'b0}, bf, af);
        check("R11 rearm match", addr_match, 1);

        // R9 release
        pulse(release_req);
        check("R9 inactive", slave_active, 0);
        base = irq_cnt;
        send_byte(8'h3C);
        check("R9 no tx_err", tx_err, 0);
        check("R9 no irq", irq_cnt - base, 0);
        bus_start();
        send_addr({7'h51, 1'b1}, bf, af);
        check("R9 rearmed irq", af, 1);
        check("R9 rearmed active", slave_active, 1);
        bus_stop();
        tx_en = 1'b0;

        // R12 bits after STOP
        base = irq_cnt;
        b = {own_addr, 1'b0};
        send_byte(b);
        send_byte(8'h00);
        check("R12 no irq", irq_cnt - base, 0);
        check("R12 flags held", {addr_match, ext_code, slave_active}, 3'b101);

        // random address bytes
        for (int k = 0; k < 40; k++) begin
            own_addr = 7'($urandom);
            b = 8'($urandom);
            if ($urandom_range(2) == 0) b[7:1] = own_addr;
            addr_case("R2/R4/R7 random", b);
            bus_stop();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule